// File: doc/BRIEF.md
# Real-Time Clock Timekeeping and Alarm Core

This core keeps wall-clock time as three counters: seconds, a packed hour/minute pair, and a running day count. A one-pulse-per-second input advances them while the core is running. The current time is compared against a programmable alarm that covers day, hour, minute and second. A minute-granular countdown gives a second event source. Three event flags are collected in a status register. Software clears a flag by writing 1 to its bit. The flags are masked by an enable register and ORed onto a single interrupt line.

Software reaches every register over a simple 32-bit bus. A write strobe commits data at a byte offset, and a read strobe returns that offset's contents on the next cycle. A run state machine has the states `RUN_HALT` and `RUN_ACTIVE`. The transition START (a control write with bit 7 set) enters `RUN_ACTIVE`, and STOP (a control write with bit 7 clear) returns to `RUN_HALT`. The countdown runs a second state machine with the states `SW_IDLE`, `SW_COUNT` and `SW_FIRE`:
- LOAD (a nonzero write) moves to `SW_COUNT`.
- CLEAR (a zero write) returns to `SW_IDLE`.
- EXPIRE (a minute rollover while the count is 1) moves to `SW_FIRE`.
- RETIRE always leaves `SW_FIRE` for `SW_IDLE` after one cycle.

Top module: `rtc_core`

## Requirements
- R1: After reset, every register reads 0 and `irq` is 0. The byte offsets are:

  | Offset | Register |
  |---|---|
  | 0x00 | hour/minute |
  | 0x04 | seconds |
  | 0x08 | alarm hour/minute |
  | 0x0C | alarm seconds |
  | 0x10 | control |
  | 0x14 | status |
  | 0x18 | enable |
  | 0x1C | countdown |
  | 0x20 | day |
  | 0x24 | alarm day |

  Read data appears on the cycle after `bus_rd`.
- R2: Control bit 7 is the run bit. Writing 1 to it makes the register read 0x80. Writing 0 makes it read 0.
- R3: While the run bit is 0, ticks change no counter and set no flag.
- R4: Seconds wrap from 59 to 0 and carry into minutes. Minutes wrap from 59 to 0 and carry into hours. Hours wrap from 23 to 0 and increment the day counter.
- R5: The hour/minute register (and its alarm twin) holds the hour in bits 15:8 and the minute in bits 7:0.
- R6: Each accepted tick while running sets status bit 4 (the 1 Hz flag). The flag is readable two cycles after the tick.
- R7: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. Writing back a value just read therefore clears every pending flag.
- R8: Status bit 2 (the alarm flag) sets when a tick brings day, hour, minute and second all equal to the alarm registers. It stays clear when any one of them differs.
- R9: `irq` is high exactly when some status bit and the same enable bit are both 1. Only bits 0, 2 and 4 of the enable register are stored.
- R10: A tick in the same cycle as a write to the hour/minute, seconds or day register is dropped. The written field takes the write data, and the other fields and flags stay unchanged.
- R11: Writing N>0 to the countdown register arms it. Each seconds wrap from 59 to 0 decrements it, and on reaching 0 it sets status bit 0 (the countdown flag). The register reads back the remaining count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse per elapsed second |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered on `bus_rd` |
| irq | output | 1 | OR of status AND enable |

## Verification
The hardest conditions to reach are the full carry chain and an alarm match across it. A tick must arrive at 23:59:59 with the alarm set to midnight of the next day, and reaching that from reset by ticking would take days of simulated seconds. The stimulus therefore writes the time counters straight to the edge of a wrap. It sets the alarm to the bench model's predicted next second, or to a value one field away, and then issues a single tick. Random rounds bias the seconds, minutes and hours toward their wrap values, so carries occur in most rounds. Directed cases collide a tick with a time write and run the countdown through two minute wraps.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int ADDR_W = 6;

    localparam logic [ADDR_W-1:0] OFS_HM     = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_SEC    = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_AHM    = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_ASEC   = 6'h0C;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_STAT   = 6'h14;
    localparam logic [ADDR_W-1:0] OFS_IEN    = 6'h18;
    localparam logic [ADDR_W-1:0] OFS_CDOWN  = 6'h1C;
    localparam logic [ADDR_W-1:0] OFS_DAY    = 6'h20;
    localparam logic [ADDR_W-1:0] OFS_ADAY   = 6'h24;

    localparam int FLAG_W   = 5;
    localparam int BIT_CD   = 0;
    localparam int BIT_ALM  = 2;
    localparam int BIT_SEC  = 4;
    localparam int BIT_RUN  = 7;
    localparam logic [FLAG_W-1:0] FLAG_MASK = 5'b10101;

    localparam int SEC_W  = 6;
    localparam int MIN_W  = 6;
    localparam int HOUR_W = 5;

    typedef enum logic {
        RUN_HALT,
        RUN_ACTIVE
    } run_state_e;

    typedef enum logic [1:0] {
        SW_IDLE,
        SW_COUNT,
        SW_FIRE
    } cd_state_e;

endpackage

// File: rtl/rtc_timebase.sv
module rtc_timebase
    import rtc_pkg::*;
#(
    parameter int DAY_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              wr_hm,
    input  logic              wr_sec,
    input  logic              wr_day,
    input  logic [31:0]       wdata,
    output logic [SEC_W-1:0]  sec_q,
    output logic [MIN_W-1:0]  min_q,
    output logic [HOUR_W-1:0] hour_q,
    output logic [DAY_W-1:0]  day_q,
    output logic              stepped_q,
    output logic              min_wrap_q
);

    localparam logic [SEC_W-1:0]  SEC_LAST  = SEC_W'(59);
    localparam logic [MIN_W-1:0]  MIN_LAST  = MIN_W'(59);
    localparam logic [HOUR_W-1:0] HOUR_LAST = HOUR_W'(23);

    logic [SEC_W-1:0]  sec_n;
    logic [MIN_W-1:0]  min_n;
    logic [HOUR_W-1:0] hour_n;
    logic [DAY_W-1:0]  day_n;
    logic              s_wrap;
    logic              m_wrap;
    logic              h_wrap;

    always_comb begin
        sec_n  = sec_q;
        min_n  = min_q;
        hour_n = hour_q;
        day_n  = day_q;
        s_wrap = (sec_q  >= SEC_LAST);
        m_wrap = (min_q  >= MIN_LAST);
        h_wrap = (hour_q >= HOUR_LAST);
        if (step) begin
            sec_n = s_wrap ? '0 : sec_q + 1'b1;
            if (s_wrap) begin
                min_n = m_wrap ? '0 : min_q + 1'b1;
                if (m_wrap) begin
                    hour_n = h_wrap ? '0 : hour_q + 1'b1;
                    if (h_wrap) begin
                        day_n = day_q + 1'b1;
                    end
                end
            end
        end
        if (wr_hm) begin
            hour_n = wdata[8 +: HOUR_W];
            min_n  = wdata[0 +: MIN_W];
        end
        if (wr_sec) begin
            sec_n = wdata[0 +: SEC_W];
        end
        if (wr_day) begin
            day_n = wdata[0 +: DAY_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec_q      <= '0;
            min_q      <= '0;
            hour_q     <= '0;
            day_q      <= '0;
            stepped_q  <= 1'b0;
            min_wrap_q <= 1'b0;
        end else begin
            sec_q      <= sec_n;
            min_q      <= min_n;
            hour_q     <= hour_n;
            day_q      <= day_n;
            stepped_q  <= step;
            min_wrap_q <= step & s_wrap;
        end
    end

    // R4
    sec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stepped_q |-> (sec_q <= SEC_LAST));

    // R4
    hour_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !wr_day && !wr_hm && sec_q == SEC_LAST && min_q == MIN_LAST && hour_q == HOUR_LAST)
        |=> (hour_q == '0 && day_q == $past(day_q) + 1'b1));

endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
    import rtc_pkg::*;
#(
    parameter int DAY_W = 16
) (
    input  logic [SEC_W-1:0]  sec,
    input  logic [MIN_W-1:0]  minute,
    input  logic [HOUR_W-1:0] hour,
    input  logic [DAY_W-1:0]  day,
    input  logic [SEC_W-1:0]  a_sec,
    input  logic [MIN_W-1:0]  a_min,
    input  logic [HOUR_W-1:0] a_hour,
    input  logic [DAY_W-1:0]  a_day,
    output logic              hit
);

    logic [3:0] field_eq;

    always_comb begin
        field_eq[0] = (sec    == a_sec);
        field_eq[1] = (minute == a_min);
        field_eq[2] = (hour   == a_hour);
        field_eq[3] = (day    == a_day);
        hit         = &field_eq;
    end

endmodule

// File: rtl/rtc_countdown.sv
module rtc_countdown
    import rtc_pkg::*;
#(
    parameter int CD_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [CD_W-1:0] load_val,
    input  logic            min_wrap,
    output logic [CD_W-1:0] count_q,
    output logic            fire
);

    localparam logic [CD_W-1:0] ONE = CD_W'(1);

    cd_state_e state_q, state_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SW_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            SW_IDLE: begin
                if (load && load_val != '0) state_n = SW_COUNT;
            end
            SW_COUNT: begin
                if (load)                           state_n = (load_val != '0) ? SW_COUNT : SW_IDLE;
                else if (min_wrap && count_q == ONE) state_n = SW_FIRE;
            end
            SW_FIRE: begin
                state_n = (load && load_val != '0) ? SW_COUNT : SW_IDLE;
            end
            default: state_n = SW_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load) begin
            count_q <= load_val;
        end else if (state_q == SW_COUNT && min_wrap) begin
            count_q <= count_q - 1'b1;
        end
    end

    always_comb begin
        fire = (state_q == SW_FIRE);
    end

    // R11
    cd_fire_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SW_FIRE) |-> (count_q == '0));

    // R11
    cd_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SW_IDLE && !load) |=> (state_q == SW_IDLE));

endmodule

// File: rtl/rtc_core.sv
module rtc_core
    import rtc_pkg::*;
#(
    parameter int DAY_W = 16,
    parameter int CD_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);

    run_state_e run_q, run_n;

    logic              wr_hm, wr_sec, wr_day, wr_ahm, wr_asec, wr_aday;
    logic              wr_ctrl, wr_stat, wr_ien, wr_cd;
    logic              time_wr;
    logic              running;
    logic              step;

    logic [SEC_W-1:0]  sec_q;
    logic [MIN_W-1:0]  min_q;
    logic [HOUR_W-1:0] hour_q;
    logic [DAY_W-1:0]  day_q;
    logic              stepped;
    logic              min_wrap;

    logic [SEC_W-1:0]  a_sec_q;
    logic [MIN_W-1:0]  a_min_q;
    logic [HOUR_W-1:0] a_hour_q;
    logic [DAY_W-1:0]  a_day_q;
    logic              alarm_hit;

    logic [CD_W-1:0]   cd_count;
    logic              cd_fire;

    logic [FLAG_W-1:0] stat_q, stat_set, stat_clr;
    logic [FLAG_W-1:0] ien_q;
    logic [31:0]       rd_mux;

    always_comb begin
        wr_hm   = bus_wr && bus_addr == OFS_HM;
        wr_sec  = bus_wr && bus_addr == OFS_SEC;
        wr_day  = bus_wr && bus_addr == OFS_DAY;
        wr_ahm  = bus_wr && bus_addr == OFS_AHM;
        wr_asec = bus_wr && bus_addr == OFS_ASEC;
        wr_aday = bus_wr && bus_addr == OFS_ADAY;
        wr_ctrl = bus_wr && bus_addr == OFS_CTRL;
        wr_stat = bus_wr && bus_addr == OFS_STAT;
        wr_ien  = bus_wr && bus_addr == OFS_IEN;
        wr_cd   = bus_wr && bus_addr == OFS_CDOWN;
        time_wr = wr_hm | wr_sec | wr_day;
    end

    // Run state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= RUN_HALT;
        end else begin
            run_q <= run_n;
        end
    end

    // Run transitions: START and STOP
    always_comb begin
        run_n = run_q;
        unique case (run_q)
            RUN_HALT:   if (wr_ctrl &&  bus_wdata[BIT_RUN]) run_n = RUN_ACTIVE;
            RUN_ACTIVE: if (wr_ctrl && !bus_wdata[BIT_RUN]) run_n = RUN_HALT;
            default:    run_n = RUN_HALT;
        endcase
    end

    // Run outputs
    always_comb begin
        running = (run_q == RUN_ACTIVE);
        step    = tick_1hz && running && !time_wr;
    end

    rtc_timebase #(.DAY_W(DAY_W)) u_timebase (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (step),
        .wr_hm      (wr_hm),
        .wr_sec     (wr_sec),
        .wr_day     (wr_day),
        .wdata      (bus_wdata),
        .sec_q      (sec_q),
        .min_q      (min_q),
        .hour_q     (hour_q),
        .day_q      (day_q),
        .stepped_q  (stepped),
        .min_wrap_q (min_wrap)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_sec_q  <= '0;
            a_min_q  <= '0;
            a_hour_q <= '0;
            a_day_q  <= '0;
        end else begin
            if (wr_ahm) begin
                a_hour_q <= bus_wdata[8 +: HOUR_W];
                a_min_q  <= bus_wdata[0 +: MIN_W];
            end
            if (wr_asec) a_sec_q <= bus_wdata[0 +: SEC_W];
            if (wr_aday) a_day_q <= bus_wdata[0 +: DAY_W];
        end
    end

    rtc_alarm_cmp #(.DAY_W(DAY_W)) u_alarm (
        .sec    (sec_q),
        .minute (min_q),
        .hour   (hour_q),
        .day    (day_q),
        .a_sec  (a_sec_q),
        .a_min  (a_min_q),
        .a_hour (a_hour_q),
        .a_day  (a_day_q),
        .hit    (alarm_hit)
    );

    rtc_countdown #(.CD_W(CD_W)) u_countdown (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wr_cd),
        .load_val (bus_wdata[CD_W-1:0]),
        .min_wrap (min_wrap),
        .count_q  (cd_count),
        .fire     (cd_fire)
    );

    always_comb begin
        stat_set          = '0;
        stat_set[BIT_SEC] = stepped;
        stat_set[BIT_ALM] = stepped & alarm_hit;
        stat_set[BIT_CD]  = cd_fire;
        stat_clr          = wr_stat ? (bus_wdata[FLAG_W-1:0] & FLAG_MASK) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
            ien_q  <= '0;
        end else begin
            stat_q <= (stat_q & ~stat_clr) | stat_set;
            if (wr_ien) ien_q <= bus_wdata[FLAG_W-1:0] & FLAG_MASK;
        end
    end

    always_comb begin
        irq = |(stat_q & ien_q);
    end

    always_comb begin
        rd_mux = '0;
        unique case (bus_addr)
            OFS_HM:    rd_mux = (32'(hour_q) << 8) | 32'(min_q);
            OFS_SEC:   rd_mux = 32'(sec_q);
            OFS_AHM:   rd_mux = (32'(a_hour_q) << 8) | 32'(a_min_q);
            OFS_ASEC:  rd_mux = 32'(a_sec_q);
            OFS_CTRL:  rd_mux = 32'(running) << BIT_RUN;
            OFS_STAT:  rd_mux = 32'(stat_q);
            OFS_IEN:   rd_mux = 32'(ien_q);
            OFS_CDOWN: rd_mux = 32'(cd_count);
            OFS_DAY:   rd_mux = 32'(day_q);
            OFS_ADAY:  rd_mux = 32'(a_day_q);
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_mux;
        end
    end

    // R3
    halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q == RUN_HALT && !time_wr) |=> ($stable(sec_q) && $stable(min_q) && $stable(hour_q) && $stable(day_q)));

    // R10
    wr_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        time_wr |=> !stepped);

    // R7
    w1c_alarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && bus_wdata[BIT_ALM] && !(stepped && alarm_hit)) |=> !stat_q[BIT_ALM]);

    // R6
    sec_flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_q[BIT_SEC]) |-> $past(stepped));

    // R8
    alarm_flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_q[BIT_ALM]) |-> $past(alarm_hit));

endmodule

// File: tb/tb_rtc_core.sv
module tb_rtc_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_1hz = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // model state
    int m_s, m_m, m_h, m_d;

    always #5 clk = ~clk;

    rtc_core dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_1hz  (tick_1hz),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic settle();
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic tick();
        @(negedge clk);
        tick_1hz = 1'b1;
        @(negedge clk);
        tick_1hz = 1'b0;
        settle();
    endtask

    task automatic wr_tick(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; tick_1hz = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; tick_1hz = 1'b0;
        settle();
    endtask

    function automatic void model_step();
        if (m_s >= 59) begin
            m_s = 0;
            if (m_m >= 59) begin
                m_m = 0;
                if (m_h >= 23) begin
                    m_h = 0;
                    m_d = (m_d + 1) % 65536;
                end else m_h++;
            end else m_m++;
        end else m_s++;
    endfunction

    function automatic logic [31:0] pack_hm(input int h, input int m);
        return (32'(h) << 8) | 32'(m);
    endfunction

    task automatic set_time(input int d, input int h, input int m, input int s);
        m_d = d; m_h = h; m_m = m; m_s = s;
        wr(6'h20, 32'(d));
        wr(6'h00, pack_hm(h, m));
        wr(6'h04, 32'(s));
    endtask

    task automatic check_time(input string req);
        logic [31:0] v;
        rd(6'h04, v); chk(v == 32'(m_s), req, v, 32'(m_s));
        rd(6'h00, v); chk(v == pack_hm(m_h, m_m), req, v, pack_hm(m_h, m_m));
        rd(6'h20, v); chk(v == 32'(m_d), req, v, 32'(m_d));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] stat_exp;
        logic [31:0] en_v;
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values at every offset
        for (int a = 0; a <= 'h24; a += 4) begin
            rd(6'(a), v);
            chk(v == 32'h0, "R1", v, 0);
        end
        chk(irq == 1'b0, "R1 irq", irq, 0);

        // R3: ticks while halted do nothing
        set_time(3, 4, 5, 6);
        tick();
        check_time("R3");
        rd(6'h14, v); chk(v == 32'h0, "R3 flags", v, 0);

        // R2: run bit readback
        wr(6'h10, 32'h80);
        rd(6'h10, v); chk(v == 32'h80, "R2 on", v, 32'h80);
        wr(6'h10, 32'h00);
        rd(6'h10, v); chk(v == 32'h0, "R2 off", v, 0);
        wr(6'h10, 32'h80);

        // R5: hour/minute packing
        wr(6'h00, 32'h0000_0A1B);
        rd(6'h00, v); chk(v == 32'h0A1B, "R5", v, 32'h0A1B);
        wr(6'h08, 32'h0000_1713);
        rd(6'h08, v); chk(v == 32'h1713, "R5 alarm", v, 32'h1713);

        // R6: 1 Hz flag
        set_time(0, 1, 2, 3);
        tick(); model_step();
        rd(6'h14, v); chk(v[4] == 1'b1, "R6", v, 32'h10);
        check_time("R6 time");

        // R7: write 0 keeps, write 1 clears, write-back clears
        wr(6'h14, 32'h0);
        rd(6'h14, v); chk(v == 32'h10, "R7 keep", v, 32'h10);
        wr(6'h14, v);
        rd(6'h14, v); chk(v == 32'h0, "R7 clear", v, 0);

        // R4 and R8: full carry with alarm at next second
        set_time(5, 23, 59, 59);
        wr(6'h24, 32'd6); wr(6'h08, pack_hm(0, 0)); wr(6'h0C, 32'd0);
        tick(); model_step();
        check_time("R4");
        rd(6'h14, v); chk(v == 32'h14, "R8 match", v, 32'h14);
        wr(6'h14, 32'h1F);

        // R8: day differs, no alarm
        set_time(7, 23, 59, 59);
        tick(); model_step();
        rd(6'h14, v); chk(v == 32'h10, "R8 day mismatch", v, 32'h10);

        // R9: irq follows status AND enable
        wr(6'h18, 32'h04);
        chk(irq == 1'b0, "R9 masked", irq, 0);
        wr(6'h18, 32'hFFFF_FFFF);
        rd(6'h18, v); chk(v == 32'h15, "R9 enable bits", v, 32'h15);
        chk(irq == 1'b1, "R9 raised", irq, 1);
        wr(6'h14, 32'h1F);
        chk(irq == 1'b0, "R9 cleared", irq, 0);

        // R10: tick colliding with a seconds write
        set_time(2, 3, 4, 10);
        wr_tick(6'h04, 32'd30);
        m_s = 30;
        check_time("R10");
        rd(6'h14, v); chk(v == 32'h0, "R10 flags", v, 0);

        // R11: countdown over two minute wraps
        wr(6'h1C, 32'd2);
        set_time(2, 3, 4, 59);
        tick(); model_step();
        rd(6'h1C, v); chk(v == 32'd1, "R11 remaining", v, 1);
        rd(6'h14, v); chk(v[0] == 1'b0, "R11 early", v, 32'h10);
        wr(6'h04, 32'd59); m_s = 59;
        tick(); model_step();
        rd(6'h1C, v); chk(v == 32'd0, "R11 zero", v, 0);
        rd(6'h14, v); chk(v == 32'h11, "R11 fired", v, 32'h11);
        wr(6'h14, 32'h1F);

        // Random rounds: R4 carries, R6/R8 flags, R9 irq
        for (int i = 0; i < 40; i++) begin
            int d, h, m, s;
            bit want_alarm;
            d = int'($urandom_range(0, 2000));
            h = ($urandom_range(0, 1) == 1) ? 23 : int'($urandom_range(0, 23));
            m = ($urandom_range(0, 1) == 1) ? 59 : int'($urandom_range(0, 59));
            s = ($urandom_range(0, 3) != 0) ? 59 : int'($urandom_range(0, 59));
            set_time(d, h, m, s);
            model_step();
            want_alarm = ($urandom_range(0, 1) == 1);
            if (want_alarm) begin
                wr(6'h24, 32'(m_d)); wr(6'h08, pack_hm(m_h, m_m)); wr(6'h0C, 32'(m_s));
            end else begin
                wr(6'h24, 32'(m_d)); wr(6'h08, pack_hm(m_h, m_m)); wr(6'h0C, 32'((m_s + 1) % 60));
            end
            en_v = 32'($urandom_range(0, 31));
            wr(6'h18, en_v);
            wr(6'h14, 32'h1F);
            m_s = s; m_m = m; m_h = h; m_d = d;
            tick(); model_step();
            check_time("R4 random");
            stat_exp = want_alarm ? 32'h14 : 32'h10;
            rd(6'h14, v); chk(v == stat_exp, "R8 random", v, stat_exp);
            chk(irq == |(stat_exp & en_v & 32'h15), "R9 random", irq, |(stat_exp & en_v & 32'h15));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule